// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is the serial control port of a clock-generation chip. It sits on a two-wire bus (SCL and SDA) as a slave, answers at 7-bit address 69h and gives a host controller read and write access to a bank of eight 8-bit control registers. The stored values drive a flat parallel bus, `regOut`, that the rest of the chip decodes into output enables, stop controls and drive modes.

The command byte that follows the address picks the access style. With its top bit set, the access is a single byte at the offset given by the low seven bits. With its top bit clear, the access is a block: a block write sends a byte count followed by data, and a block read returns a byte count followed by data. In both directions the data starts at register 0 and moves upward. SDA is modelled as an input plus an open-drain pull-down enable. Both bus lines are brought into the system clock domain through two flops before any decoding.

Some readback bits do not come from storage. Register 6 returns three frequency-select straps in its low bits. Its bit 3, a software stop control, reads as 0 whenever either the stored bit or the external stop pin is low. Register 7 is a fixed identifier.

Top module: `smb_reg_slave`

## Requirements
- R1: After reset, `regOut` holds FFh, F6h, FFh, 00h, 07h and 00h for registers 0 to 5. Register 6 holds {5'b00011, strapSel}. Register 7 holds 28h. Register i is at `regOut[8*i+7:8*i]`.
- R2: The slave pulls SDA low in the ACK slot of an address byte equal to {7'h69, rw}. For any other address it gives no ACK and leaves SDA released until the next START.
- R3: A command byte with bit 7 = 1 selects a single-byte access at offset = bits 6:0. In a write, the following data byte is stored at that offset. Every byte the master writes is ACKed.
- R4: A single-byte read (write command, repeated START, address with rw = 1) returns the register at the selected offset, most significant bit first.
- R5: A command byte with bit 7 = 0 selects a block access starting at register 0. In a block write, the first byte after the command is a byte count. The count is not stored. The bytes after it are written to registers 0, 1, 2 and upward.
- R6: A block read first returns the count 08h, then registers 0, 1, 2 and upward, for as long as the master ACKs. After the master NACKs, the slave releases SDA.
- R7: Register 7 and register 6 bits 2:0 are read-only. Writes to them, and writes to offsets 8 to 127, are ACKed and change nothing. Reads from offsets 8 to 127 return 00h.
- R8: Register 6 bit 3 reads back as the stored bit AND `stopPinN`. The other bits of register 6 read back as stored.
- R9: The slave changes its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | 1 = pull SDA low (open drain) |
| strapSel | input | 3 | Frequency-select straps, already latched |
| stopPinN | input | 1 | External stop pin, active low |
| regOut | output | 64 | All registers, register i at bits 8*i+7:8*i |

## Verification
Directed single-byte writes and reads at in-range, read-only and out-of-range offsets show whether the offset decode and the write masks are correct. Block writes and block reads of different lengths show whether the byte count is consumed instead of stored, whether a read starts with the count, and whether the pointer steps correctly. A frame to a wrong address, followed by further bytes, shows whether the slave stays silent until the next START. A seeded random mix of single-byte traffic, with the strap and stop-pin inputs changing between frames, shows whether the live bits of register 6 track their inputs while the stored bits keep their values.

// File: rtl/smb_reg_pkg.sv
package smb_reg_pkg;

  localparam int STAT_IDX = 6;   // register with live status bits
  localparam int ID_IDX   = 7;   // fixed identifier register

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_WR, S_WR_ACK, S_RD, S_RD_ACK
  } smbState_t;

  // strobes from the bit-level control to the register datapath
  typedef struct packed {
    logic       startSeen;
    logic       wrStb;
    logic [7:0] wrData;
    logic       rdAdv;
  } smbStrobe_t;

  function automatic logic [7:0] regDefault(int idx, logic [7:0] idValue);
    case (idx)
      0, 2:     return 8'hFF;
      1:        return 8'hF6;
      4:        return 8'h07;
      STAT_IDX: return 8'h18;
      ID_IDX:   return idValue;
      default:  return 8'h00;
    endcase
  endfunction

  // bits a host write may change
  function automatic logic [7:0] wrMask(int idx);
    if (idx < STAT_IDX) return 8'hFF;
    if (idx == STAT_IDX) return 8'hF8;
    return 8'h00;
  endfunction

endpackage

// File: rtl/smb_reg_ctrl.sv
module smb_reg_ctrl
  import smb_reg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdByte,
  output logic       sdaOe,
  output smbStrobe_t stb
);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS;
  logic       startC, stopC, sclRise, sclFall;
  smbState_t  state;
  logic [3:0] bitCnt;
  logic [7:0] shifter, txShift;
  logic       isRead, mAck;

  assign sclS    = sclSync[1];
  assign sdaS    = sdaSync[1];
  assign startC  = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopC   = sclS & sclPrev & ~sdaPrev & sdaS;
  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bitCnt  <= '0;
      shifter <= '0;
      txShift <= '0;
      isRead  <= 1'b0;
      mAck    <= 1'b0;
      sdaOe   <= 1'b0;
      stb     <= '0;
    end else begin
      stb <= '0;
      if (startC) begin
        state         <= S_ADDR;
        bitCnt        <= '0;
        sdaOe         <= 1'b0;
        stb.startSeen <= 1'b1;
      end else if (stopC) begin
        state <= S_IDLE;
        sdaOe <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_WR: begin
            if (sclRise) begin
              shifter <= {shifter[6:0], sdaS};
              bitCnt  <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              if (state == S_WR) begin
                sdaOe      <= 1'b1;
                stb.wrStb  <= 1'b1;
                stb.wrData <= shifter;
                state      <= S_WR_ACK;
              end else if (shifter[7:1] == SLAVE_ADDR) begin
                sdaOe  <= 1'b1;
                isRead <= shifter[0];
                state  <= S_ADDR_ACK;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_WR_ACK: if (sclFall) begin
            sdaOe  <= 1'b0;
            bitCnt <= '0;
            state  <= S_WR;
          end
          S_RD: if (sclFall) begin
            if (bitCnt == 4'd8) begin
              sdaOe <= 1'b0;
              state <= S_RD_ACK;
            end else begin
              sdaOe   <= ~txShift[6];
              txShift <= {txShift[6:0], 1'b0};
              bitCnt  <= bitCnt + 4'd1;
            end
          end
          S_ADDR_ACK, S_RD_ACK: begin
            if (sclRise) mAck <= ~sdaS;
            if (sclFall) begin
              if ((state == S_ADDR_ACK && isRead) || (state == S_RD_ACK && mAck)) begin
                txShift   <= rdByte;
                sdaOe     <= ~rdByte[7];
                stb.rdAdv <= 1'b1;
                bitCnt    <= 4'd1;
                state     <= S_RD;
              end else if (state == S_ADDR_ACK) begin
                sdaOe  <= 1'b0;
                bitCnt <= '0;
                state  <= S_WR;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R2: when idle (no address match yet) the slave never pulls SDA
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !sdaOe);

  // R9: pull-down is held while SCL stays high (no START/STOP seen)
  p_sda_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && sclPrev && !startC && !stopC) |=> $stable(sdaOe));

endmodule

// File: rtl/smb_reg_file.sv
module smb_reg_file
  import smb_reg_pkg::*;
#(
  parameter int         NREG     = 8,
  parameter logic [7:0] ID_VALUE = 8'h28
) (
  input  logic              clk,
  input  logic              rstN,
  input  smbStrobe_t        stb,
  input  logic [2:0]        strapSel,
  input  logic              stopPinN,
  output logic [7:0]        rdByte,
  output logic [NREG*8-1:0] regOut
);

  localparam int IDXW = $clog2(NREG);

  logic [7:0]      regs [NREG];
  logic [6:0]      ptr;
  logic [IDXW-1:0] ptrIdx;
  logic            inRange, blockMode, rdFirst;
  logic [1:0]      phase;     // 0 command, 1 count, 2 data
  logic [7:0]      viewByte;

  assign ptrIdx  = ptr[IDXW-1:0];
  assign inRange = (int'(ptr) < NREG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regs[i] <= regDefault(i, ID_VALUE);
      ptr       <= '0;
      blockMode <= 1'b0;
      rdFirst   <= 1'b0;
      phase     <= '0;
    end else if (stb.startSeen) begin
      phase   <= '0;
      rdFirst <= 1'b1;
    end else if (stb.wrStb) begin
      rdFirst <= 1'b0;
      case (phase)
        2'd0: begin
          blockMode <= ~stb.wrData[7];
          ptr       <= stb.wrData[7] ? stb.wrData[6:0] : 7'd0;
          phase     <= stb.wrData[7] ? 2'd2 : 2'd1;
        end
        2'd1: phase <= 2'd2;
        default: begin
          if (inRange)
            regs[ptrIdx] <= (regs[ptrIdx] & ~wrMask(int'(ptrIdx)))
                          | (stb.wrData & wrMask(int'(ptrIdx)));
          ptr <= ptr + 7'd1;
        end
      endcase
    end else if (stb.rdAdv) begin
      rdFirst <= 1'b0;
      if (!(rdFirst && blockMode)) ptr <= ptr + 7'd1;
    end
  end

  always_comb begin
    viewByte = regs[ptrIdx];
    if (ptrIdx == IDXW'(STAT_IDX))
      viewByte = {regs[ptrIdx][7:4], regs[ptrIdx][3] & stopPinN, strapSel};
  end

  assign rdByte = (rdFirst && blockMode) ? 8'(NREG) : (inRange ? viewByte : 8'h00);

  for (genvar g = 0; g < NREG; g++) begin : g_out
    if (g == STAT_IDX) begin : g_stat
      assign regOut[g*8 +: 8] = {regs[g][7:3], strapSel};
    end else begin : g_plain
      assign regOut[g*8 +: 8] = regs[g];
    end
  end

  // R6: every data byte sent advances the pointer by one
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdAdv && !(rdFirst && blockMode)) |=> (ptr == $past(ptr) + 7'd1));

  // R6: the leading count byte of a block read leaves the pointer in place
  p_count_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdAdv && rdFirst && blockMode) |=> $stable(ptr));

  // R7: a data write beyond the bank leaves every stored register alone
  p_oob_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrStb && phase == 2'd2 && !inRange) |=>
      ($stable(regOut[NREG*8-1:STAT_IDX*8+8]) && $stable(regOut[STAT_IDX*8-1:0])));

endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_reg_pkg::*;
#(
  parameter int         NREG       = 8,
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter logic [7:0] ID_VALUE   = 8'h28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [2:0]        strapSel,
  input  logic              stopPinN,
  output logic [NREG*8-1:0] regOut
);

  smbStrobe_t stb;
  logic [7:0] rdByte;

  smb_reg_ctrl #(.SLAVE_ADDR(SLAVE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdByte(rdByte), .sdaOe(sdaOe), .stb(stb)
  );

  smb_reg_file #(.NREG(NREG), .ID_VALUE(ID_VALUE)) u_file (
    .clk(clk), .rstN(rstN), .stb(stb), .strapSel(strapSel),
    .stopPinN(stopPinN), .rdByte(rdByte), .regOut(regOut)
  );

endmodule

// File: tb/smb_reg_slave_bench.sv
module smb_reg_slave_bench;

  localparam int HALF = 10;
  localparam logic [6:0] ADDR = 7'h69;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, sdaLine, stopPinN = 1'b1;
  logic [2:0] strap = 3'd5;
  logic [63:0] regOut;
  logic [7:0] mdl [8];
  logic [7:0] wrBuf [8];
  logic [7:0] rdBuf [8];
  int checks = 0, failures = 0, sclHi = 0, oeViol = 0;
  logic prevOe = 1'b0;

  always #5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  smb_reg_slave u_smb_reg_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .strapSel(strap), .stopPinN(stopPinN), .regOut(regOut)
  );

  // R9 monitor: pull-down must not move during a settled SCL-high phase
  always @(posedge clk) begin
    if (sclM) sclHi = sclHi + 1; else sclHi = 0;
    if (rstN && sclHi > 3 && sdaOe !== prevOe) oeViol = oeViol + 1;
    prevOe = sdaOe;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures = failures + 1;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] maskOf(int idx);
    if (idx < 6) return 8'hFF;
    if (idx == 6) return 8'hF8;
    return 8'h00;
  endfunction

  function automatic logic [7:0] expOut(int idx);
    return (idx == 6) ? {mdl[6][7:3], strap} : mdl[idx];
  endfunction

  function automatic logic [7:0] expView(int idx);
    if (idx > 7) return 8'h00;
    if (idx == 6) return {mdl[6][7:4], mdl[6][3] & stopPinN, strap};
    return mdl[idx];
  endfunction

  task automatic mdlWrite(int idx, logic [7:0] d);
    if (idx < 8) mdl[idx] = (mdl[idx] & ~maskOf(idx)) | (d & maskOf(idx));
  endtask

  task automatic halfWait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; halfWait(); sclM = 1'b1; halfWait();
    sdaM = 1'b0; halfWait(); sclM = 1'b0;
  endtask

  task automatic stopCond();
    sdaM = 1'b0; halfWait(); sclM = 1'b1; halfWait(); sdaM = 1'b1; halfWait();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; halfWait(); sclM = 1'b1; halfWait(); sclM = 1'b0;
    end
    sdaM = 1'b1; halfWait(); sclM = 1'b1; halfWait();
    ack = ~sdaLine;
    sclM = 1'b0;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] b);
    b = '0;
    sdaM = 1'b1;
    for (int i = 0; i < 8; i++) begin
      halfWait(); sclM = 1'b1; halfWait();
      b = {b[6:0], sdaLine};
      sclM = 1'b0;
    end
    sdaM = ~giveAck; halfWait(); sclM = 1'b1; halfWait(); sclM = 1'b0;
    sdaM = 1'b1;
  endtask

  task automatic byteWrite(input int off, input logic [7:0] d, output logic ok);
    logic a1, a2, a3;
    startCond();
    sendByte({ADDR, 1'b0}, a1);
    sendByte({1'b1, 7'(off)}, a2);
    sendByte(d, a3);
    stopCond();
    ok = a1 & a2 & a3;
    mdlWrite(off, d);
  endtask

  task automatic byteRead(input int off, output logic [7:0] d);
    logic a;
    startCond();
    sendByte({ADDR, 1'b0}, a);
    sendByte({1'b1, 7'(off)}, a);
    startCond();
    sendByte({ADDR, 1'b1}, a);
    recvByte(1'b0, d);
    stopCond();
  endtask

  task automatic checkOut(input string tag);
    for (int i = 0; i < 8; i++)
      check(regOut[i*8 +: 8] === expOut(i), tag, regOut[i*8 +: 8], expOut(i));
  endtask

  logic ok, a;
  logic [7:0] d, cnt;

  initial begin
    void'($urandom(32'd4242));
    mdl[0] = 8'hFF; mdl[1] = 8'hF6; mdl[2] = 8'hFF; mdl[3] = 8'h00;
    mdl[4] = 8'h07; mdl[5] = 8'h00; mdl[6] = 8'h18; mdl[7] = 8'h28;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    checkOut("R1 reset value");
    check(sdaOe == 1'b0, "R1 sda released after reset", {7'd0, sdaOe}, 8'h00);

    // R3: single-byte write, every byte ACKed
    byteWrite(3, 8'hA5, ok);
    check(ok, "R3 byte write acked", {7'd0, ok}, 8'h01);
    checkOut("R3 byte write stored");

    // R4: single-byte reads
    byteRead(3, d); check(d == 8'hA5, "R4 read reg3", d, 8'hA5);
    byteRead(1, d); check(d == 8'hF6, "R4 read reg1", d, 8'hF6);

    // R7: read-only and out-of-range offsets
    byteRead(7, d); check(d == 8'h28, "R7 id read", d, 8'h28);
    byteWrite(7, 8'h00, ok);
    check(ok, "R7 write to id acked", {7'd0, ok}, 8'h01);
    byteWrite(9, 8'h5A, ok);
    check(ok, "R7 out-of-range write acked", {7'd0, ok}, 8'h01);
    checkOut("R7 ignored writes");
    byteRead(9, d); check(d == 8'h00, "R7 out-of-range read", d, 8'h00);
    byteRead(100, d); check(d == 8'h00, "R7 far offset read", d, 8'h00);
    byteWrite(6, 8'hFF, ok);
    check(regOut[55:48] == {5'b11111, strap}, "R7 strap bits kept", regOut[55:48], {5'b11111, strap});

    // R8: live stop bit
    stopPinN = 1'b0;
    byteRead(6, d); check(d == expView(6), "R8 stop pin low", d, expView(6));
    stopPinN = 1'b1;
    byteRead(6, d); check(d == expView(6), "R8 stop pin high", d, expView(6));
    byteWrite(6, 8'h10, ok);
    byteRead(6, d); check(d == expView(6), "R8 stored stop low", d, expView(6));

    // R2: wrong address gets no ACK, stays silent until next START
    startCond();
    sendByte({7'h6A, 1'b0}, a);
    check(!a, "R2 wrong address not acked", {7'd0, a}, 8'h00);
    sendByte(8'h83, a);
    check(!a, "R2 silent after mismatch", {7'd0, a}, 8'h00);
    sendByte(8'h00, a);
    stopCond();
    checkOut("R2 no change after mismatch");
    startCond();
    sendByte({ADDR, 1'b0}, a);
    check(a, "R2 matching address acked", {7'd0, a}, 8'h01);
    stopCond();

    // R5: block write with count byte
    wrBuf[0] = 8'h11; wrBuf[1] = 8'h22; wrBuf[2] = 8'h33;
    startCond();
    sendByte({ADDR, 1'b0}, a);
    sendByte(8'h00, a);
    sendByte(8'd3, a);
    check(a, "R5 count byte acked", {7'd0, a}, 8'h01);
    for (int j = 0; j < 3; j++) begin
      sendByte(wrBuf[j], a);
      check(a, "R5 block data acked", {7'd0, a}, 8'h01);
      mdlWrite(j, wrBuf[j]);
    end
    stopCond();
    checkOut("R5 block write");

    // R6: full block read
    startCond();
    sendByte({ADDR, 1'b0}, a);
    sendByte(8'h00, a);
    startCond();
    sendByte({ADDR, 1'b1}, a);
    recvByte(1'b1, cnt);
    check(cnt == 8'h08, "R6 block count", cnt, 8'h08);
    for (int j = 0; j < 8; j++) recvByte(j != 7, rdBuf[j]);
    stopCond();
    for (int j = 0; j < 8; j++)
      check(rdBuf[j] == expView(j), "R6 block data", rdBuf[j], expView(j));
    check(sdaOe == 1'b0, "R6 released after nack", {7'd0, sdaOe}, 8'h00);

    // R6: short block read ended after two data bytes
    startCond();
    sendByte({ADDR, 1'b0}, a);
    sendByte(8'h00, a);
    startCond();
    sendByte({ADDR, 1'b1}, a);
    recvByte(1'b1, cnt);
    recvByte(1'b1, rdBuf[0]);
    recvByte(1'b0, rdBuf[1]);
    stopCond();
    check(rdBuf[0] == expView(0) && rdBuf[1] == expView(1), "R6 short block read", rdBuf[1], expView(1));

    // random single-byte traffic
    for (int n = 0; n < 50; n++) begin
      int op, off;
      logic [7:0] rv;
      op = $urandom_range(0, 3);
      off = $urandom_range(0, 9);
      rv = 8'($urandom_range(0, 255));
      if (op < 2) begin
        byteWrite(off, rv, ok);
        check(ok, "R3 random write acked", {7'd0, ok}, 8'h01);
        check(regOut[off % 8 * 8 +: 8] == expOut(off % 8), "R3 random write", regOut[off % 8 * 8 +: 8], expOut(off % 8));
      end else if (op == 2) begin
        byteRead(off, d);
        check(d == expView(off), "R4 random read", d, expView(off));
      end else begin
        strap = 3'($urandom_range(0, 7));
        stopPinN = 1'($urandom_range(0, 1));
        byteRead(6, d);
        check(d == expView(6), "R8 random status read", d, expView(6));
      end
    end

    check(oeViol == 0, "R9 sda moved while scl high", 8'(oeViol), 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule